// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general purpose I/O controller for a number of pins that is a multiple of 32. Software sees one group of 32-bit words per feature, one word for every 32 pins. The groups hold the sampled pin level, the drive direction, set-only and clear-only output strobes, rising and falling edge enables, and sticky edge status. A final group of twice the size packs a 2-bit alternate-function selector for each pin.

Pin inputs pass through a two-flop synchroniser. The synchronised value feeds the level word and the edge detector. The detector compares each pin with its value one cycle earlier. Every enabled transition sets a status bit, and that bit stays set until software writes a 1 to it. One interrupt line is high while any status bit is set.

The register port is a plain single-cycle bus. A write is taken on the clock edge while select and write are both high. Read data is combinational from the address while select is high and write is low.

Top module: `gpio_bank_ctl`

## Requirements
- R1: With NREG = NPINS/32, word k of feature group g sits at byte offset (g*NREG + k)*4. The group order is level (0), direction (1), set (2), clear (3), rising enable (4), falling enable (5), status (6), alternate function (7). Word k covers pins 32k to 32k+31, and pin p uses bit p%32.
- R2: A direction bit of 1 drives `pin_oe` high for that pin, so the pin is an output. A 0 makes the pin an input. Direction words read back what was written.
- R3: Writing 1 to a bit of a set word drives that pin's output high. Writing 1 to a bit of a clear word drives it low. Zero bits leave the output unchanged, and the output changes on the write's clock edge.
- R4: The level word reads the pin inputs after the two-flop synchroniser. A pin change is not visible one clock later and is visible two clocks later. Writes to the level group change nothing.
- R5: Rising and falling enables act independently per pin, and both may be set. An edge whose enable is clear sets no status bit.
- R6: A status bit is set by an enabled edge and cleared by writing 1 to it. Writing 0 leaves it unchanged, and writing all ones clears every pending bit in the word.
- R7: When an enabled edge and a 1 written to the same status bit fall on the same clock edge, the bit stays set.
- R8: `irq` is high exactly while at least one status bit is set.
- R9: Alternate-function word j (group 7, word index j from 0 to 2*NREG-1) holds pins 16j to 16j+15. Pin p uses bits (p%16)*2+1 to (p%16)*2 and drives `pin_altsel[2p+1:2p]`. A value of 0 means plain GPIO, and the words read back what was written.
- R10: Reset clears outputs, directions, enables, status and alternate selectors. Set and clear words read as 0. Offsets at or beyond (9*NREG)*4 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | NPINS | Pad input values, asynchronous |
| pin_out | output | NPINS | Output drive values |
| pin_oe | output | NPINS | Output enables |
| pin_altsel | output | 2*NPINS | Alternate-function selectors |
| irq | output | 1 | Combined edge interrupt |

## Verification
The assertions assume that bus signals are stable around the clock edge and that only one register word is written per cycle. The bench meets this by driving the bus only on falling edges and holding each write for a single rising edge. The assertions also assume that pin inputs change away from the clock edge. The bench changes `pin_in` on falling edges and then waits out the synchroniser before it samples a status bit. For the collision case in R7, the bench places the clear write in the exact cycle in which the detector's event is live.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  typedef enum logic [2:0] {
    G_LEVEL = 3'd0,
    G_DIR   = 3'd1,
    G_SET   = 3'd2,
    G_CLR   = 3'd3,
    G_RISE  = 3'd4,
    G_FALL  = 3'd5,
    G_STAT  = 3'd6,
    G_ALT   = 3'd7
  } grp_e;

  // feature group of a word index for a given number of words per group
  function automatic int unsigned word_group(int unsigned w, int unsigned nreg);
    return w / nreg;
  endfunction

  // word position inside its group
  function automatic int unsigned word_slot(int unsigned w, int unsigned nreg);
    return w % nreg;
  endfunction

  // edge event for a vector: enabled rise or enabled fall
  function automatic logic [31:0] edge_evt(logic [31:0] cur, logic [31:0] old,
                                           logic [31:0] ren, logic [31:0] fen);
    return (ren & cur & ~old) | (fen & ~cur & old);
  endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpb_edge.sv
module gpb_edge
  import gpb_pkg::*;
#(
  parameter int NPINS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] rise_en,
  input  logic [NPINS-1:0] fall_en,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] status,
  output logic             irq
);
  localparam int NREG = NPINS / 32;

  logic [NPINS-1:0] prev;
  logic [NPINS-1:0] evt;

  for (genvar k = 0; k < NREG; k++) begin : g_word
    assign evt[k*32 +: 32] = edge_evt(lvl[k*32 +: 32], prev[k*32 +: 32],
                                      rise_en[k*32 +: 32], fall_en[k*32 +: 32]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= '0;
      status <= '0;
    end else begin
      prev   <= lvl;
      status <= (status & ~clr) | evt;
    end
  end

  assign irq = |status;

  // R5: every live event is latched on the next edge
  p_edge_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status & $past(evt)) == $past(evt)));
  // R6: a status bit never rises without an event
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status & ~$past(status) & ~$past(evt)) == '0));
  // R7: an event beats a clear of the same bit
  p_edge_beats_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & clr)) |=> ((status & $past(evt & clr)) == $past(evt & clr)));
  // R8: the interrupt only rises after an event
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|evt));
endmodule

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl
  import gpb_pkg::*;
#(
  parameter int NPINS  = 64,
  parameter int ADDR_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic [2*NPINS-1:0] pin_altsel,
  output logic               irq
);
  localparam int unsigned NREG     = NPINS / 32;
  localparam int unsigned ALT_BASE = 7 * NREG;
  localparam int unsigned ALT_END  = 9 * NREG;

  logic [NPINS-1:0]   lvl, dir_q, out_q, rise_q, fall_q, status;
  logic [NPINS-1:0]   set_m, clr_m, stat_clr;
  logic [NREG-1:0]    dir_wr, rise_wr, fall_wr, lvl_wr;
  logic [2*NREG-1:0]  alt_wr;
  logic [2*NPINS-1:0] alt_q;
  logic               wr_en, in_std, in_alt;
  int unsigned        widx, grp, slot, aslot;

  gpb_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
  );

  gpb_edge #(.NPINS(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise_en(rise_q), .fall_en(fall_q),
    .clr(stat_clr), .status(status), .irq(irq)
  );

  // address decode
  always_comb begin
    widx   = 32'(bus_addr >> 2);
    grp    = word_group(widx, NREG);
    slot   = word_slot(widx, NREG);
    in_std = (widx < ALT_BASE);
    in_alt = (widx >= ALT_BASE) && (widx < ALT_END);
    aslot  = in_alt ? (widx - ALT_BASE) : 0;
    wr_en  = bus_sel && bus_wr;
  end

  // write strobes and masks
  always_comb begin
    set_m = '0; clr_m = '0; stat_clr = '0;
    dir_wr = '0; rise_wr = '0; fall_wr = '0; lvl_wr = '0; alt_wr = '0;
    if (wr_en && in_std) begin
      for (int unsigned k = 0; k < NREG; k++) begin
        if (slot == k) begin
          case (grp)
            32'(G_LEVEL): lvl_wr[k] = 1'b1;
            32'(G_DIR):   dir_wr[k] = 1'b1;
            32'(G_SET):   set_m[k*32 +: 32] = bus_wdata;
            32'(G_CLR):   clr_m[k*32 +: 32] = bus_wdata;
            32'(G_RISE):  rise_wr[k] = 1'b1;
            32'(G_FALL):  fall_wr[k] = 1'b1;
            32'(G_STAT):  stat_clr[k*32 +: 32] = bus_wdata;
            default: ;
          endcase
        end
      end
    end
    if (wr_en && in_alt) begin
      for (int unsigned k = 0; k < 2*NREG; k++) begin
        if (aslot == k) alt_wr[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      alt_q  <= '0;
    end else begin
      out_q <= (out_q | set_m) & ~clr_m;
      for (int unsigned k = 0; k < NREG; k++) begin
        if (dir_wr[k])  dir_q[k*32 +: 32]  <= bus_wdata;
        if (rise_wr[k]) rise_q[k*32 +: 32] <= bus_wdata;
        if (fall_wr[k]) fall_q[k*32 +: 32] <= bus_wdata;
      end
      for (int unsigned k = 0; k < 2*NREG; k++) begin
        if (alt_wr[k]) alt_q[k*32 +: 32] <= bus_wdata;
      end
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (in_std) begin
        for (int unsigned k = 0; k < NREG; k++) begin
          if (slot == k) begin
            case (grp)
              32'(G_LEVEL): bus_rdata = lvl[k*32 +: 32];
              32'(G_DIR):   bus_rdata = dir_q[k*32 +: 32];
              32'(G_RISE):  bus_rdata = rise_q[k*32 +: 32];
              32'(G_FALL):  bus_rdata = fall_q[k*32 +: 32];
              32'(G_STAT):  bus_rdata = status[k*32 +: 32];
              default:      bus_rdata = '0;
            endcase
          end
        end
      end else if (in_alt) begin
        for (int unsigned k = 0; k < 2*NREG; k++) begin
          if (aslot == k) bus_rdata = alt_q[k*32 +: 32];
        end
      end
    end
  end

  assign pin_out    = out_q;
  assign pin_oe     = dir_q;
  assign pin_altsel = alt_q;

  // R3: set strobes drive ones, clear strobes drive zeros
  p_set_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_m) |=> ((pin_out & $past(set_m)) == $past(set_m)));
  p_clr_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_m) |=> ((pin_out & $past(clr_m)) == '0));
  // R4: a write to the level group leaves the configuration untouched
  p_level_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_wr) |=> ($stable(pin_oe) && $stable(pin_out) && $stable(pin_altsel)));
  // R1: at most one word strobe fires per access
  p_one_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dir_wr, rise_wr, fall_wr, lvl_wr, alt_wr}));
endmodule

// File: tb/gpio_bank_ctl_test.sv
module gpio_bank_ctl_test;
  localparam int NP = 64;
  localparam int NR = NP / 32;
  localparam int AW = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NP-1:0]   pin_in = '0;
  logic [NP-1:0]   pin_out, pin_oe;
  logic [2*NP-1:0] pin_altsel;
  logic            irq;
  int              n_chk = 0, n_fail = 0;
  logic [31:0]     rd;

  always #2 clk = ~clk;

  gpio_bank_ctl #(.NPINS(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_altsel(pin_altsel), .irq(irq)
  );

  // R1: byte offset of word k in group g
  function automatic logic [AW-1:0] adr(int g, int k);
    return AW'((g * NR + k) * 4);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_wr(logic [AW-1:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset pin_out", 64'(pin_out), 64'h0);
    chk("R10 reset pin_oe", 64'(pin_oe), 64'h0);
    chk("R10 reset altsel", 64'(|pin_altsel), 64'h0);
    chk("R10 reset irq", 64'(irq), 64'h0);
    do_rd(adr(6, 1), rd); chk("R10 reset status", 64'(rd), 64'h0);
  endtask

  task automatic t_dir;
    do_wr(adr(1, 1), 32'hA5A5_0F0F);
    chk("R2 oe upper", 64'(pin_oe[63:32]), 64'hA5A5_0F0F);
    chk("R1 oe lower untouched", 64'(pin_oe[31:0]), 64'h0);
    do_rd(adr(1, 1), rd); chk("R2 dir readback", 64'(rd), 64'hA5A5_0F0F);
  endtask

  task automatic t_setclr;
    do_wr(adr(2, 0), 32'h0000_00F0);
    chk("R3 set", 64'(pin_out), 64'h0000_0000_0000_00F0);
    do_wr(adr(3, 0), 32'h0000_0030);
    chk("R3 clear", 64'(pin_out), 64'h0000_0000_0000_00C0);
    do_wr(adr(2, 1), 32'h0000_0001);
    chk("R3 set word1", 64'(pin_out), 64'h0000_0001_0000_00C0);
    do_rd(adr(2, 0), rd); chk("R10 set reads zero", 64'(rd), 64'h0);
  endtask

  task automatic t_level;
    pin_in = 64'h1234_5678_9ABC_DEF0;
    step(1);
    do_rd(adr(0, 0), rd); chk("R4 not yet visible", 64'(rd), 64'h0);
    step(1);
    do_rd(adr(0, 0), rd); chk("R4 level word0", 64'(rd), 64'h9ABC_DEF0);
    do_rd(adr(0, 1), rd); chk("R4 level word1", 64'(rd), 64'h1234_5678);
    do_wr(adr(0, 0), 32'hFFFF_FFFF);
    do_rd(adr(0, 0), rd); chk("R4 level ignores write", 64'(rd), 64'h9ABC_DEF0);
    chk("R4 write leaves outputs", 64'(pin_out), 64'h0000_0001_0000_00C0);
    pin_in = '0;
    step(3);
    chk("R5 no enables no irq", 64'(irq), 64'h0);
    do_rd(adr(6, 0), rd); chk("R5 no enables no status", 64'(rd), 64'h0);
  endtask

  task automatic t_rise;
    do_wr(adr(4, 0), 32'h4);
    pin_in[2] = 1'b1;
    step(3);
    do_rd(adr(6, 0), rd); chk("R5 rise latched", 64'(rd), 64'h4);
    chk("R8 irq set", 64'(irq), 64'h1);
    do_wr(adr(6, 0), 32'h4);
    chk("R8 irq cleared", 64'(irq), 64'h0);
    pin_in[2] = 1'b0;
    step(3);
    do_rd(adr(6, 0), rd); chk("R5 fall not enabled", 64'(rd), 64'h0);
  endtask

  task automatic t_both;
    do_wr(adr(4, 1), 32'h100);
    do_wr(adr(5, 1), 32'h100);
    pin_in[40] = 1'b1;
    step(3);
    do_rd(adr(6, 1), rd); chk("R5 both rise", 64'(rd), 64'h100);
    do_wr(adr(6, 1), 32'h100);
    do_rd(adr(6, 1), rd); chk("R6 w1c", 64'(rd), 64'h0);
    pin_in[40] = 1'b0;
    step(3);
    do_rd(adr(6, 1), rd); chk("R5 both fall", 64'(rd), 64'h100);
  endtask

  task automatic t_w1c;
    pin_in[2] = 1'b1;
    step(3);
    do_wr(adr(6, 0), 32'h0);
    do_rd(adr(6, 0), rd); chk("R6 zero write keeps", 64'(rd), 64'h4);
    do_wr(adr(6, 0), 32'hFFFF_FFFF);
    do_wr(adr(6, 1), 32'hFFFF_FFFF);
    do_rd(adr(6, 0), rd); chk("R6 all ones word0", 64'(rd), 64'h0);
    do_rd(adr(6, 1), rd); chk("R6 all ones word1", 64'(rd), 64'h0);
    chk("R8 irq low when empty", 64'(irq), 64'h0);
  endtask

  task automatic t_race;
    pin_in[2] = 1'b0;
    step(3);
    pin_in[2] = 1'b1;
    step(2);
    do_wr(adr(6, 0), 32'h4);
    do_rd(adr(6, 0), rd); chk("R7 edge survives clear", 64'(rd), 64'h4);
    chk("R7 irq stays", 64'(irq), 64'h1);
    do_wr(adr(6, 0), 32'h4);
  endtask

  task automatic t_alt;
    do_wr(adr(7, 1), 32'h0000_0020);
    chk("R9 pin18 field", 64'(pin_altsel[37:36]), 64'h2);
    chk("R9 pin17 field", 64'(pin_altsel[35:34]), 64'h0);
    do_wr(adr(7, 3), 32'hC000_0000);
    chk("R9 pin63 field", 64'(pin_altsel[127:126]), 64'h3);
    do_rd(adr(7, 1), rd); chk("R9 alt readback", 64'(rd), 64'h20);
  endtask

  task automatic t_unmapped;
    do_rd(AW'(9 * NR * 4), rd); chk("R10 unmapped read", 64'(rd), 64'h0);
    do_wr(AW'(9 * NR * 4), 32'hFFFF_FFFF);
    do_rd(AW'(10'h3FC), rd); chk("R10 far read", 64'(rd), 64'h0);
    do_rd(adr(1, 1), rd); chk("R10 unmapped write harmless", 64'(rd), 64'hA5A5_0F0F);
    do_rd(adr(7, 3), rd); chk("R10 alt unchanged", 64'(rd), 64'hC000_0000);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_dir;
    t_setclr;
    t_level;
    t_rise;
    t_both;
    t_w1c;
    t_race;
    t_alt;
    t_unmapped;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule